// File: doc/BRIEF.md
# Control Pin Function Multiplexer

This block drives five general control pins of an interface device. Every pin has its own 4-bit function code, held in configuration registers that stand in for nonvolatile settings. The code chooses one source for that pin. The sources are:

- transmit-enable for an RS485 line driver
- an active-low power-enable
- active-low activity LEDs for transmit, receive or either direction
- an active-low suspend indicator
- the base clock and copies of it divided by 2, 4 and 8
- pass-through of the bit-bang read and write strobes
- software GPIO on the lower four pins

Each pin picks its function without regard to the others. GPIO pins stay usable while the serial side is busy.

LED functions stretch one-cycle activity events into a pulse of fixed length. An event that arrives during a pulse starts the pulse again. GPIO pins use a direction bit per pin. The levels on the pins are passed through two flops into a readable register. The block moves no data stream, so every pin is a plain level with an output-enable beside it.

Top module: `ctlpin_mux`

## Requirements
- R1: While reset is asserted and on release, the LED pulse stretchers are idle and the divider is cleared. Pins coded 2, 3 or 4 read 1, and a pin coded 7 reads 0.
- R2: Code 0 drives the pin high exactly while `tx_active` is 1.
- R3: Code 1 drives the pin low only when `configured` is 1 and `suspend` is 0. In all other cases it drives the pin high.
- R4: Code 5 drives the pin low while `suspend` is 1 and high otherwise.
- R5: Code 2 reacts to `tx_evt` only, code 3 to `rx_evt` only, and code 4 to either event. After the clock edge that samples the event, the pin reads 0 for exactly PULSE_LEN cycles (default 4096) and then returns to 1.
- R6: An event during an active pulse reloads the stretcher, so the pin stays low for a full PULSE_LEN cycles counted from the new event.
- R7: Code 6 outputs the base clock itself. Codes 7, 8 and 9 output square waves with 50% duty and periods of 2, 4 and 8 clock cycles.
- R8: Code 11 passes `bb_wr_n` to the pin and code 12 passes `bb_rd_n`.
- R9: Code 10 on pins 0 to 3 works as GPIO. If `gpio_dir` bit i is 1, the pin drives `gpio_wr` bit i with `pin_oe` high. If the bit is 0, `pin_oe` is low.
- R10: `gpio_rd` bit i shows `pin_in` bit i as sampled two clock edges earlier.
- R11: Code 10 on pin 4, and codes 13 to 15 on any pin, drive the pin low with `pin_oe` high.
- R12: Every pin applies its own code at the same time as the others. GPIO on pins 0 to 3 works while LED pulses are running on another pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock (the divide-by-1 clock output) |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_cfg | input | 20 | Function code of pin i in bits [4i+3:4i] |
| tx_evt | input | 1 | One-cycle transmit activity event |
| rx_evt | input | 1 | One-cycle receive activity event |
| tx_active | input | 1 | High while the serial transmitter is sending |
| suspend | input | 1 | High while the bus is suspended |
| configured | input | 1 | High once the host has configured the device |
| bb_rd_n | input | 1 | Bit-bang read strobe, active low |
| bb_wr_n | input | 1 | Bit-bang write strobe, active low |
| gpio_dir | input | 4 | GPIO direction per pin, 1 = output |
| gpio_wr | input | 4 | GPIO output levels |
| gpio_rd | output | 4 | Synchronised GPIO input levels |
| pin_in | input | 4 | Pad levels of pins 0 to 3 |
| pin_out | output | 5 | Pin output levels |
| pin_oe | output | 5 | Pin output enables |

## Verification
The LED stretchers are tested three ways: with a transmit-only event, with a receive-only event, and with a second event partway through a pulse. The first two show that each LED code reacts to the right event. The third shows that a new event restarts the count and is not simply ignored. All three clock outputs run at once, and counting transitions and high samples over 16 cycles separates the three divide ratios. The status codes are tried with every combination of `suspend` and `configured`, which separates the power-enable logic from the suspend indicator. GPIO is tested with mixed direction bits, with the same code on the fifth pin, and with input steps timed edge by edge.

// File: rtl/ctlpin_pkg.sv
`timescale 1ns/1ps
package ctlpin_pkg;
  localparam int FN_W = 4;
  localparam int DIV_TAPS = 3;

  typedef enum logic [FN_W-1:0] {
    FN_TXEN     = 4'd0,
    FN_PWR_N    = 4'd1,
    FN_TXLED_N  = 4'd2,
    FN_RXLED_N  = 4'd3,
    FN_ANYLED_N = 4'd4,
    FN_SLEEP_N  = 4'd5,
    FN_CLK_D1   = 4'd6,
    FN_CLK_D2   = 4'd7,
    FN_CLK_D4   = 4'd8,
    FN_CLK_D8   = 4'd9,
    FN_GPIO     = 4'd10,
    FN_WRSTB    = 4'd11,
    FN_RDSTB    = 4'd12
  } ctlpin_fn_e;
endpackage

// File: rtl/ctlpin_clkdiv.sv
`timescale 1ns/1ps
module ctlpin_clkdiv #(
  parameter int TAPS = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TAPS-1:0] taps
);
  logic [TAPS-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q + 1'b1;
  end

  assign taps = cnt_q;

  assert_div_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (taps[0] != $past(taps[0])));
endmodule

// File: rtl/ctlpin_pulse.sv
`timescale 1ns/1ps
module ctlpin_pulse #(
  parameter int LEN = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic led_n
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (trig)         cnt_q <= CW'(LEN);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign led_n = (cnt_q == '0);

  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt_q == CW'(LEN)));
  assert_countdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && led_n) |=> led_n);
endmodule

// File: rtl/ctlpin_sync.sv
`timescale 1ns/1ps
module ctlpin_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/ctlpin_mux.sv
`timescale 1ns/1ps
module ctlpin_mux
  import ctlpin_pkg::*;
#(
  parameter int NPINS     = 5,
  parameter int NGPIO     = 4,
  parameter int PULSE_LEN = 4096
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPINS*FN_W-1:0] pin_cfg,
  input  logic                  tx_evt,
  input  logic                  rx_evt,
  input  logic                  tx_active,
  input  logic                  suspend,
  input  logic                  configured,
  input  logic                  bb_rd_n,
  input  logic                  bb_wr_n,
  input  logic [NGPIO-1:0]      gpio_dir,
  input  logic [NGPIO-1:0]      gpio_wr,
  output logic [NGPIO-1:0]      gpio_rd,
  input  logic [NGPIO-1:0]      pin_in,
  output logic [NPINS-1:0]      pin_out,
  output logic [NPINS-1:0]      pin_oe
);
  localparam int NLED = 3;

  logic [DIV_TAPS-1:0] taps;
  logic [NLED-1:0]     led_trig;
  logic [NLED-1:0]     led_n;
  logic [1:0]          up_q;

  ctlpin_clkdiv #(.TAPS(DIV_TAPS)) u_div (
    .clk(clk), .rst_n(rst_n), .taps(taps)
  );

  assign led_trig = {tx_evt | rx_evt, rx_evt, tx_evt};

  for (genvar k = 0; k < NLED; k++) begin : g_led
    ctlpin_pulse #(.LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .trig(led_trig[k]), .led_n(led_n[k])
    );
  end

  ctlpin_sync #(.W(NGPIO)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(gpio_rd)
  );

  // cycles since reset, used only to arm history-based checks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            up_q <= '0;
    else if (up_q != 2'd3) up_q <= up_q + 1'b1;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    localparam bit HAS_GPIO = (g < NGPIO);
    logic [FN_W-1:0] raw;
    ctlpin_fn_e      fn;
    logic            gdir, gval;
    logic            drv, val;

    assign raw = pin_cfg[g*FN_W +: FN_W];
    assign fn  = ctlpin_fn_e'(raw);

    if (HAS_GPIO) begin : g_io
      assign gdir = gpio_dir[g];
      assign gval = gpio_wr[g];
    end else begin : g_noio
      assign gdir = 1'b1;
      assign gval = 1'b0;
    end

    always_comb begin
      drv = 1'b1;
      val = 1'b0;
      case (fn)
        FN_TXEN:     val = tx_active;
        FN_PWR_N:    val = !(configured && !suspend);
        FN_TXLED_N:  val = led_n[0];
        FN_RXLED_N:  val = led_n[1];
        FN_ANYLED_N: val = led_n[2];
        FN_SLEEP_N:  val = !suspend;
        FN_CLK_D1:   val = clk;
        FN_CLK_D2:   val = taps[0];
        FN_CLK_D4:   val = taps[1];
        FN_CLK_D8:   val = taps[2];
        FN_GPIO: begin
          if (HAS_GPIO) begin
            drv = gdir;
            val = gdir & gval;
          end
        end
        FN_WRSTB:    val = bb_wr_n;
        FN_RDSTB:    val = bb_rd_n;
        default:     val = 1'b0;
      endcase
    end

    assign pin_out[g] = val;
    assign pin_oe[g]  = drv;

    assert_bad_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (raw > 4'd12 || (raw == 4'd10 && !HAS_GPIO)) |-> (!pin_out[g] && pin_oe[g]));
    assert_gpio_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_GPIO && raw == 4'd10 && !gdir) |-> !pin_oe[g]);
    assert_sleep_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (raw == 4'd5) |-> (pin_out[g] == !suspend));
    assert_half_clk_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q == 2'd3 && raw == 4'd7 && $past(raw) == 4'd7) |-> (pin_out[g] != $past(pin_out[g])));
  end

  assert_sync_delay_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q == 2'd3) |-> (gpio_rd == $past(pin_in, 2)));
endmodule

// File: tb/ctlpin_mux_bench.sv
`timescale 1ns/1ps
module ctlpin_mux_bench;
  localparam int NP = 5;
  localparam int NG = 4;
  localparam int PL = 4096;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [19:0]   pin_cfg = '0;
  logic          tx_evt = 0, rx_evt = 0, tx_active = 0, suspend = 0, configured = 0;
  logic          bb_rd_n = 1, bb_wr_n = 1;
  logic [NG-1:0] gpio_dir = '0, gpio_wr = '0, pin_in = '0;
  logic [NG-1:0] gpio_rd;
  logic [NP-1:0] pin_out, pin_oe;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ctlpin_mux #(.NPINS(NP), .NGPIO(NG), .PULSE_LEN(PL)) u_ctlpin_mux (
    .clk(clk), .rst_n(rst_n), .pin_cfg(pin_cfg), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .tx_active(tx_active), .suspend(suspend), .configured(configured),
    .bb_rd_n(bb_rd_n), .bb_wr_n(bb_wr_n), .gpio_dir(gpio_dir), .gpio_wr(gpio_wr),
    .gpio_rd(gpio_rd), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int c0, input int c1, input int c2, input int c3, input int c4);
    pin_cfg = {4'(c4), 4'(c3), 4'(c2), 4'(c1), 4'(c0)};
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic count_low(input int p, output int n);
    n = 0;
    while (pin_out[p] == 1'b0 && n < 10000) begin
      n++;
      step();
    end
  endtask

  task automatic pulse_evt(input bit tx, input bit rx);
    @(negedge clk);
    tx_evt = tx; rx_evt = rx;
    @(negedge clk);
    tx_evt = 0; rx_evt = 0;
    #1;
  endtask

  task automatic t_reset();
    set_cfg(2, 3, 4, 7, 0);
    rst_n = 0;
    repeat (3) step();
    chk("R1 reset pins", pin_out, 5'b00111);
    chk("R1 reset gpio_rd", gpio_rd, 0);
    @(negedge clk); rst_n = 1; #1;
    chk("R1 after release", pin_out, 5'b00111);
  endtask

  task automatic t_led();
    int n;
    set_cfg(2, 3, 4, 0, 0);
    step();
    pulse_evt(1, 0);
    chk("R5 rx led ignores tx", pin_out[1], 1);
    chk("R5 any led on tx", pin_out[2], 0);
    count_low(0, n);
    chk("R5 tx led length", n, PL);
    chk("R5 any led ended", pin_out[2], 1);
    pulse_evt(0, 1);
    chk("R5 tx led ignores rx", pin_out[0], 1);
    count_low(2, n);
    chk("R5 any led length on rx", n, PL);
    chk("R5 rx led ended", pin_out[1], 1);
  endtask

  task automatic t_retrig();
    int n;
    set_cfg(2, 0, 0, 0, 0);
    pulse_evt(1, 0);
    repeat (1000) step();
    chk("R6 still low mid pulse", pin_out[0], 0);
    pulse_evt(1, 0);
    count_low(0, n);
    chk("R6 restarted length", n, PL);
  endtask

  task automatic t_status();
    set_cfg(0, 1, 5, 1, 5);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      suspend = c[0]; configured = c[1]; tx_active = c[0] ^ c[1];
      #1;
      chk("R2 tx enable", pin_out[0], c[0] ^ c[1]);
      chk("R3 power enable", pin_out[1], (c[1] && !c[0]) ? 0 : 1);
      chk("R4 suspend ind", pin_out[2], c[0] ? 0 : 1);
      chk("R12 same code two pins", {pin_out[3], pin_out[4]}, {pin_out[1], pin_out[2]});
    end
    suspend = 0; configured = 0; tx_active = 0;
  endtask

  task automatic t_clocks();
    int tr[3];
    int hi[3];
    logic [2:0] prev;
    set_cfg(7, 8, 9, 6, 0);
    step();
    @(posedge clk); #1;
    chk("R7 div1 high phase", pin_out[3], 1);
    @(negedge clk); #1;
    chk("R7 div1 low phase", pin_out[3], 0);
    for (int k = 0; k < 3; k++) begin tr[k] = 0; hi[k] = 0; end
    prev = pin_out[2:0];
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 3; k++) if (prev[k]) hi[k]++;
      step();
      for (int k = 0; k < 3; k++) if (pin_out[k] != prev[k]) tr[k]++;
      prev = pin_out[2:0];
    end
    chk("R7 div2 toggles", tr[0], 16);
    chk("R7 div4 toggles", tr[1], 8);
    chk("R7 div8 toggles", tr[2], 4);
    chk("R7 div2 duty", hi[0], 8);
    chk("R7 div4 duty", hi[1], 8);
    chk("R7 div8 duty", hi[2], 8);
  endtask

  task automatic t_strobes();
    set_cfg(11, 12, 0, 0, 11);
    @(negedge clk); bb_wr_n = 0; bb_rd_n = 1; #1;
    chk("R8 write strobe", {pin_out[4], pin_out[1], pin_out[0]}, 3'b010);
    @(negedge clk); bb_wr_n = 1; bb_rd_n = 0; #1;
    chk("R8 read strobe", {pin_out[4], pin_out[1], pin_out[0]}, 3'b101);
    bb_rd_n = 1;
  endtask

  task automatic t_gpio();
    set_cfg(10, 10, 10, 10, 10);
    @(negedge clk); gpio_dir = 4'b0101; gpio_wr = 4'b0011; #1;
    chk("R9 gpio oe", pin_oe[3:0], 4'b0101);
    chk("R9 gpio driven levels", {pin_out[2], pin_out[0]}, 2'b01);
    chk("R11 pin4 gpio low", {pin_oe[4], pin_out[4]}, 2'b10);
    set_cfg(10, 10, 10, 10, 2);
    pulse_evt(1, 0);
    @(negedge clk); gpio_wr = 4'b0100; #1;
    chk("R12 gpio during led pulse", {pin_out[4], pin_out[2], pin_out[0]}, 3'b010);
    @(negedge clk); pin_in = 4'h0;
    repeat (3) step();
    @(negedge clk); pin_in = 4'hA; #1;
    chk("R10 no change before edges", gpio_rd, 0);
    step();
    chk("R10 one edge not enough", gpio_rd, 0);
    step();
    chk("R10 after two edges", gpio_rd, 4'hA);
  endtask

  task automatic t_badcodes();
    set_cfg(13, 14, 15, 13, 15);
    @(negedge clk); tx_active = 1; suspend = 1; #1;
    chk("R11 reserved codes low", pin_out, 0);
    chk("R11 reserved codes driven", pin_oe, 5'b11111);
    tx_active = 0; suspend = 0;
  endtask

  initial begin
    t_reset();
    t_led();
    t_retrig();
    t_status();
    t_clocks();
    t_strobes();
    t_gpio();
    t_badcodes();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule